// File: doc/BRIEF.md
# Multiply-Divide Unit with Condition Flags

This unit performs unsigned and signed multiplication and division on operands 8, 16 or 32 bits wide, taken from the low lanes of two full-width input words. A pulse on `start` captures the operation code, the lane size and both operands. Exactly one cycle later `done` pulses. At that point the unit presents a truncated product, or a quotient together with a remainder. It also presents a five-bit condition-flag vector and a mask saying which flags the operation updates.

The surrounding datapath writes `result` back into the destination register when `wr_dst` is high. It writes `remainder` into the register that held the divisor when `wr_rem` is high. It merges the flags under `flag_mask`. A zero divisor turns the whole operation into a no-op: nothing is written and no flag is touched, but `done` still pulses so that the sequencer never stalls.

Top module: `muldiv_unit`

## Requirements
- R1: `op` selects 00 = unsigned multiply, 01 = signed multiply, 10 = unsigned divide, 11 = signed divide. `size` selects the lane width: 00 = 8, 01 = 16, 10 or 11 = 32 bits. Operand bits above the lane are ignored, and result bits above the lane read zero.
- R2: Unsigned multiply returns the product truncated to the lane. Flag C (bit 1) is set when the full product does not fit in the lane. `flag_mask` is 5'b11011 (Z, C, P, N), so O is not updated.
- R3: Signed multiply returns the truncated product. Flag O (bit 2) is set when the signed product does not fit in the lane. `flag_mask` is 5'b11101 (Z, O, P, N), so C is not updated.
- R4: A divide returns the quotient on `result` and the remainder on `remainder`, with both `wr_dst` and `wr_rem` high. A multiply raises only `wr_dst` and leaves `remainder` unchanged.
- R5: Signed divide truncates the quotient toward zero, and the remainder carries the sign of the dividend. `flag_mask` is 5'b11101 for signed divide and 5'b11001 for unsigned divide.
- R6: A signed divide of the most negative lane value by -1 returns the most negative value as the quotient and zero as the remainder, and sets O. Every other signed divide clears O.
- R7: A divisor whose lane is zero writes nothing. `wr_dst`, `wr_rem`, `flags` and `flag_mask` are all zero, `result` and `remainder` keep their previous values, and `done` still pulses.
- R8: Flags are laid out as Z = bit 0, C = 1, O = 2, P = 3, N = 4. Z means the lane result is zero, P means the result is even, and N is the lane's top bit. The result is the product or the quotient. Flag bits outside `flag_mask` read zero.
- R9: `done` is high for exactly the one cycle after each cycle in which `start` is high. The operands and operation are sampled only in the `start` cycle.
- R10: Between operations, `result`, `remainder`, `flags` and `flag_mask` hold their values, and `wr_dst` and `wr_rem` are high only together with `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation; samples op, size and operands |
| op | input | 2 | Operation code |
| size | input | 2 | Lane width code |
| opa | input | DATA_W | Multiplicand or dividend |
| opb | input | DATA_W | Multiplier or divisor |
| done | output | 1 | One-cycle completion pulse |
| result | output | DATA_W | Product or quotient, zero above the lane |
| remainder | output | DATA_W | Remainder of the last divide |
| wr_dst | output | 1 | Write strobe for the destination |
| wr_rem | output | 1 | Write strobe for the remainder |
| flags | output | 5 | Z, C, O, P, N values (bits 0 to 4) |
| flag_mask | output | 5 | Flags updated by this operation |

## Verification
The bench targets the lane boundaries, where a design that tests fit against the full word instead of the lane would miss C or O. Examples are 0x80 times 2 in 8 bits, and a signed 16-bit product of exactly 32768. Signed division is driven with negative dividends and negative divisors, and with the most negative value divided by -1 at every width. A design that floors instead of truncating, or that lets the 32-bit case overflow, returns the wrong quotient or remainder sign. A zero divisor whose upper, out-of-lane bits are nonzero catches a design that tests the whole word: such a design writes a result, or clobbers the held remainder, instead of leaving every output alone. Operands are scrambled right after `start`, so a design that samples late returns a result computed from the wrong operands.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

  typedef enum logic [1:0] {
    MD_MULU = 2'b00,
    MD_MULI = 2'b01,
    MD_DIVU = 2'b10,
    MD_DIVI = 2'b11
  } md_op_e;

  localparam int NFLAG = 5;
  localparam int FZ = 0;
  localparam int FC = 1;
  localparam int FO = 2;
  localparam int FP = 3;
  localparam int FN = 4;

  typedef logic [NFLAG-1:0] md_flags_t;

  localparam md_flags_t UPD_MULU = md_flags_t'((1 << FZ) | (1 << FC) | (1 << FP) | (1 << FN));
  localparam md_flags_t UPD_SGN  = md_flags_t'((1 << FZ) | (1 << FO) | (1 << FP) | (1 << FN));
  localparam md_flags_t UPD_DIVU = md_flags_t'((1 << FZ) | (1 << FP) | (1 << FN));

endpackage

// File: rtl/mdu_ext.sv
// Widens a lane to the full word: sign-fill when sgn, zero-fill otherwise.
module mdu_ext #(
  parameter int W = 32
) (
  input  logic [W-1:0] din,
  input  logic [W-1:0] lmask,
  input  logic         sgn,
  output logic [W-1:0] dout
);
  logic [W-1:0] top_bit;
  logic         neg;

  always_comb begin
    top_bit = lmask ^ (lmask >> 1);
    neg     = sgn & (|(din & top_bit));
    dout    = neg ? (din | ~lmask) : (din & lmask);
  end
endmodule

// File: rtl/mdu_mul.sv
// Full-width product of two widened lanes, truncation and fit test.
module mdu_mul #(
  parameter int W = 32
) (
  input  logic [W-1:0] ea,
  input  logic [W-1:0] eb,
  input  logic [W-1:0] lmask,
  input  logic         sgn,
  output logic [W-1:0] prod,
  output logic         no_fit
);
  localparam int W2 = 2 * W;

  logic [W2-1:0] wa, wb, full, refit;
  logic [W-1:0]  top_bit;
  logic          pmsb;

  always_comb begin
    wa      = {{W{sgn & ea[W-1]}}, ea};
    wb      = {{W{sgn & eb[W-1]}}, eb};
    full    = wa * wb;
    prod    = full[W-1:0] & lmask;
    top_bit = lmask ^ (lmask >> 1);
    pmsb    = |(prod & top_bit);
    refit   = (sgn & pmsb) ? {{W{1'b1}}, prod | ~lmask} : {{W{1'b0}}, prod};
    no_fit  = (full != refit);
  end
endmodule

// File: rtl/mdu_div.sv
// Quotient and remainder of widened lanes, with zero and min/-1 detection.
module mdu_div #(
  parameter int W = 32
) (
  input  logic [W-1:0] ea,
  input  logic [W-1:0] eb,
  input  logic [W-1:0] lmask,
  input  logic         sgn,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem,
  output logic         by_zero,
  output logic         min_case
);
  logic [W-1:0] eb_safe, q_raw, r_raw;

  always_comb begin
    by_zero  = (eb == '0);
    eb_safe  = by_zero ? W'(1) : eb;
    min_case = sgn && (ea == ~(lmask >> 1)) && (eb == '1);
    if (sgn) begin
      q_raw = $signed(ea) / $signed(eb_safe);
      r_raw = $signed(ea) % $signed(eb_safe);
    end else begin
      q_raw = ea / eb_safe;
      r_raw = ea % eb_safe;
    end
    if (min_case) begin
      quo = ea & lmask;
      rem = '0;
    end else begin
      quo = q_raw & lmask;
      rem = r_raw & lmask;
    end
  end
endmodule

// File: rtl/mdu_flags.sv
// Condition flags from a lane result, masked by the update set.
module mdu_flags
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] res,
  input  logic [W-1:0] lmask,
  input  logic         carry,
  input  logic         ovf,
  input  md_flags_t    upd,
  output md_flags_t    flg
);
  md_flags_t raw;

  always_comb begin
    raw     = '0;
    raw[FZ] = (res == '0);
    raw[FC] = carry;
    raw[FO] = ovf;
    raw[FP] = ~res[0];
    raw[FN] = |(res & (lmask ^ (lmask >> 1)));
    flg     = raw & upd;
  end
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic              done,
  output logic [DATA_W-1:0] result,
  output logic [DATA_W-1:0] remainder,
  output logic              wr_dst,
  output logic              wr_rem,
  output logic [4:0]        flags,
  output logic [4:0]        flag_mask
);
  localparam int QW = DATA_W / 4;
  localparam int HW = DATA_W / 2;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  // decode
  md_op_e      op_e;
  logic        is_div, sgn;
  logic [DATA_W-1:0] lmask;
  md_flags_t   upd;

  always_comb begin
    op_e   = md_op_e'(op);
    is_div = (op_e == MD_DIVU) || (op_e == MD_DIVI);
    sgn    = (op_e == MD_MULI) || (op_e == MD_DIVI);
    unique case (op_e)
      MD_MULU: upd = UPD_MULU;
      MD_DIVU: upd = UPD_DIVU;
      default: upd = UPD_SGN;
    endcase
    case (size)
      2'b00:   lmask = {{(DATA_W-QW){1'b0}}, {QW{1'b1}}};
      2'b01:   lmask = {{(DATA_W-HW){1'b0}}, {HW{1'b1}}};
      default: lmask = '1;
    endcase
  end

  // operand widening
  logic [DATA_W-1:0] raw_opnd [2];
  logic [DATA_W-1:0] ext_opnd [2];
  assign raw_opnd[0] = opa;
  assign raw_opnd[1] = opb;

  for (genvar g = 0; g < 2; g++) begin : g_ext
    mdu_ext #(.W(DATA_W)) u_ext (
      .din  (raw_opnd[g]),
      .lmask(lmask),
      .sgn  (sgn),
      .dout (ext_opnd[g])
    );
  end

  logic [DATA_W-1:0] prod, quo, rem;
  logic              no_fit, by_zero, min_case;

  mdu_mul #(.W(DATA_W)) u_mul (
    .ea(ext_opnd[0]), .eb(ext_opnd[1]), .lmask(lmask), .sgn(sgn),
    .prod(prod), .no_fit(no_fit)
  );

  mdu_div #(.W(DATA_W)) u_div (
    .ea(ext_opnd[0]), .eb(ext_opnd[1]), .lmask(lmask), .sgn(sgn),
    .quo(quo), .rem(rem), .by_zero(by_zero), .min_case(min_case)
  );

  logic [DATA_W-1:0] res_sel;
  logic              carry_sel, ovf_sel;
  md_flags_t         flg_new;

  always_comb begin
    res_sel   = is_div ? quo : prod;
    carry_sel = !is_div && !sgn && no_fit;
    ovf_sel   = sgn && (is_div ? min_case : no_fit);
  end

  mdu_flags #(.W(DATA_W)) u_flags (
    .res(res_sel), .lmask(lmask), .carry(carry_sel), .ovf(ovf_sel),
    .upd(upd), .flg(flg_new)
  );

  // state
  logic              done_q, done_d;
  logic [DATA_W-1:0] res_q, res_d, rem_q, rem_d;
  logic              wd_q, wd_d, wr_q, wr_d;
  md_flags_t         flg_q, flg_d, msk_q, msk_d;

  always_comb begin
    done_d = start;
    res_d  = res_q;
    rem_d  = rem_q;
    wd_d   = wd_q;
    wr_d   = wr_q;
    flg_d  = flg_q;
    msk_d  = msk_q;
    if (start) begin
      if (is_div && by_zero) begin
        wd_d  = 1'b0;
        wr_d  = 1'b0;
        flg_d = '0;
        msk_d = '0;
      end else begin
        res_d = res_sel;
        if (is_div) rem_d = rem;
        wd_d  = 1'b1;
        wr_d  = is_div;
        flg_d = flg_new;
        msk_d = upd;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      done_q <= 1'b0;
      res_q  <= '0;
      rem_q  <= '0;
      wd_q   <= 1'b0;
      wr_q   <= 1'b0;
      flg_q  <= '0;
      msk_q  <= '0;
    end else begin
      done_q <= done_d;
      if (start) begin
        res_q <= res_d;
        rem_q <= rem_d;
        wd_q  <= wd_d;
        wr_q  <= wr_d;
        flg_q <= flg_d;
        msk_q <= msk_d;
      end
    end
  end

  assign done      = done_q;
  assign result    = res_q;
  assign remainder = rem_q;
  assign wr_dst    = done_q & wd_q;
  assign wr_rem    = done_q & wr_q;
  assign flags     = flg_q;
  assign flag_mask = msk_q;

endmodule

// File: rtl/mdu_checker.sv
module mdu_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              done,
  input logic [DATA_W-1:0] result,
  input logic [DATA_W-1:0] remainder,
  input logic              wr_dst,
  input logic              wr_rem,
  input logic [4:0]        flag_mask
);
  a_r9_done_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);

  a_r9_done_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start));

  a_r10_no_idle_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (!wr_dst && !wr_rem));

  a_r10_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(result) && $stable(remainder) && $stable(flag_mask)));

  a_r4_rem_with_dst: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rem |-> wr_dst);

  a_r3_one_arith_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flag_mask[2:1]));

  a_r7_silent_zero_div: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !wr_dst) |-> (flag_mask == 5'b00000));
endmodule

bind muldiv_unit mdu_checker #(.DATA_W(DATA_W)) u_mdu_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done),
  .result(result), .remainder(remainder), .wr_dst(wr_dst),
  .wr_rem(wr_rem), .flag_mask(flag_mask)
);

// File: tb/muldiv_unit_test.sv
module muldiv_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [1:0]  op_i, size_i;
  logic [31:0] opa, opb;
  logic        done, wr_dst, wr_rem;
  logic [31:0] result, remainder;
  logic [4:0]  flags, flag_mask;

  always #5 clk = ~clk;

  muldiv_unit #(.DATA_W(32)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op_i), .size(size_i),
    .opa(opa), .opb(opb), .done(done), .result(result), .remainder(remainder),
    .wr_dst(wr_dst), .wr_rem(wr_rem), .flags(flags), .flag_mask(flag_mask)
  );

  typedef struct {
    logic [31:0] res;
    logic [31:0] rem;
    logic        wd;
    logic        wrm;
    logic [4:0]  flg;
    logic [4:0]  msk;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  int          n_checks = 0;
  int          n_errs   = 0;
  logic [31:0] last_res = '0;
  logic [31:0] last_rem = '0;
  bit          ended    = 0;

  task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errs++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
    end
  endtask

  // reference model, built from the requirements
  function automatic exp_t model(int op, int sz, logic [31:0] a, logic [31:0] b,
                                 logic [31:0] pres, logic [31:0] prem, string tag);
    exp_t        e;
    int          w;
    logic [63:0] m, ua, ub, full, r64, q64, rm64;
    longint      sa, sb, sp, back;
    logic        c, o;
    logic [4:0]  raw;
    w    = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
    m    = (64'd1 << w) - 64'd1;
    ua   = {32'b0, a} & m;
    ub   = {32'b0, b} & m;
    sa   = ua[w-1] ? (longint'(ua) - longint'(64'd1 << w)) : longint'(ua);
    sb   = ub[w-1] ? (longint'(ub) - longint'(64'd1 << w)) : longint'(ub);
    c    = 1'b0;
    o    = 1'b0;
    r64  = '0;
    e.tag = tag; e.res = pres; e.rem = prem;
    e.wd = 1'b0; e.wrm = 1'b0; e.flg = '0; e.msk = '0;
    case (op)
      0: begin
        full = ua * ub;
        r64  = full & m;
        c    = (full >> w) != 64'd0;
        e.msk = 5'b11011; e.wd = 1'b1; e.res = r64[31:0];
      end
      1: begin
        sp   = sa * sb;
        r64  = 64'(sp) & m;
        back = r64[w-1] ? (longint'(r64) - longint'(64'd1 << w)) : longint'(r64);
        o    = (sp != back);
        e.msk = 5'b11101; e.wd = 1'b1; e.res = r64[31:0];
      end
      2: if (ub != 64'd0) begin
        r64  = ua / ub;
        rm64 = ua % ub;
        e.msk = 5'b11001; e.wd = 1'b1; e.wrm = 1'b1;
        e.res = r64[31:0]; e.rem = rm64[31:0];
      end
      default: if (sb != 0) begin
        if (sa == -(longint'(1) << (w - 1)) && sb == -1) begin
          r64  = m & (64'd1 << (w - 1));
          rm64 = '0;
          o    = 1'b1;
        end else begin
          q64  = 64'(sa / sb);
          rm64 = 64'(sa % sb) & m;
          r64  = q64 & m;
        end
        e.msk = 5'b11101; e.wd = 1'b1; e.wrm = 1'b1;
        e.res = r64[31:0]; e.rem = rm64[31:0];
      end
    endcase
    if (e.wd) begin
      raw   = {r64[w-1], ~r64[0], o, c, (r64 == 64'd0)};
      e.flg = raw & e.msk;
    end
    return e;
  endfunction

  // driver: computes the expectation, pushes it, pulses start, then scrambles inputs
  task automatic run_op(int op, int sz, logic [31:0] a, logic [31:0] b, string tag);
    exp_t e;
    @(negedge clk);
    e = model(op, sz, a, b, last_res, last_rem, tag);
    last_res = e.res;
    last_rem = e.rem;
    sb_q.push_back(e);
    start  = 1'b1;
    op_i   = 2'(op);
    size_i = 2'(sz);
    opa    = a;
    opb    = b;
    @(negedge clk);
    start  = 1'b0;
    opa    = ~a;
    opb    = ~b ^ 32'h5a5a_a5a5;
    op_i   = op_i ^ 2'b01;
    size_i = size_i ^ 2'b01;
    @(negedge clk);
  endtask

  // monitor: pops and compares on each done
  always @(negedge clk) begin
    if (rst_n && done === 1'b1) begin
      if (sb_q.size() == 0) begin
        chk("R9", "unexpected done", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(e.tag, "result", result, e.res);
        chk(e.tag, "remainder", remainder, e.rem);
        chk(e.tag, "wr_dst", {31'b0, wr_dst}, {31'b0, e.wd});
        chk(e.tag, "wr_rem (R4)", {31'b0, wr_rem}, {31'b0, e.wrm});
        chk(e.tag, "flag_mask", {27'b0, flag_mask}, {27'b0, e.msk});
        chk(e.tag, "flags (R8)", {27'b0, flags}, {27'b0, e.flg});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_errs++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; op_i = '0; size_i = '0; opa = '0; opb = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // reset state
    chk("R10", "reset done", {31'b0, done}, 32'd0);
    chk("R10", "reset result", result, 32'd0);
    chk("R10", "reset mask", {27'b0, flag_mask}, 32'd0);
    chk("R10", "reset wr_dst", {31'b0, wr_dst}, 32'd0);

    // R1 lane selection with junk above the lane
    run_op(0, 0, 32'hABCD_0012, 32'h7700_0003, "R1");
    run_op(1, 1, 32'h1234_FFFD, 32'hFFFF_0005, "R1");
    // R2 unsigned multiply
    run_op(0, 0, 32'h0000_0080, 32'h0000_0002, "R2");
    run_op(0, 1, 32'h0000_FFFF, 32'h0000_FFFF, "R2");
    run_op(0, 2, 32'h0001_0000, 32'h0001_0000, "R2");
    run_op(0, 2, 32'h0000_1234, 32'h0000_0010, "R2");
    // R3 signed multiply
    run_op(1, 0, 32'h0000_00FD, 32'h0000_0005, "R3");
    run_op(1, 0, 32'h0000_0040, 32'h0000_0002, "R3");
    run_op(1, 1, 32'h0000_8000, 32'h0000_FFFF, "R3");
    run_op(1, 2, 32'h7FFF_FFFF, 32'h0000_0002, "R3");
    run_op(1, 2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3");
    // R4 unsigned divide
    run_op(2, 0, 32'h0000_00C8, 32'h0000_0007, "R4");
    run_op(2, 1, 32'h0000_FFFF, 32'h0000_0100, "R4");
    run_op(2, 2, 32'hFFFF_FFFF, 32'h0000_0003, "R4");
    run_op(2, 0, 32'h0000_0003, 32'h0000_0005, "R8");
    // R5 signed divide truncation and remainder sign
    run_op(3, 0, 32'h0000_00F9, 32'h0000_0002, "R5");
    run_op(3, 0, 32'h0000_0007, 32'h0000_00FE, "R5");
    run_op(3, 1, 32'h0000_FF9C, 32'h0000_0007, "R5");
    run_op(3, 2, 32'hFFFF_FF9C, 32'hFFFF_FFF9, "R5");
    // R6 most negative by -1
    run_op(3, 0, 32'h0000_0080, 32'h0000_00FF, "R6");
    run_op(3, 1, 32'h0000_8000, 32'h0000_FFFF, "R6");
    run_op(3, 2, 32'h8000_0000, 32'hFFFF_FFFF, "R6");
    // R7 zero divisor, including junk above the lane
    run_op(2, 0, 32'h0000_0055, 32'h0000_0100, "R7");
    run_op(3, 2, 32'h1234_5678, 32'h0000_0000, "R7");
    run_op(2, 1, 32'h0000_0009, 32'h0000_0003, "R4");
    run_op(3, 1, 32'h0000_0009, 32'hABCD_0000, "R7");

    // R10 hold between operations, and R9 one done per start
    repeat (4) @(negedge clk);
    chk("R10", "idle result", result, last_res);
    chk("R10", "idle remainder", remainder, last_rem);
    chk("R10", "idle wr_dst", {31'b0, wr_dst}, 32'd0);
    chk("R9", "idle done", {31'b0, done}, 32'd0);
    chk("R9", "pending items", sb_q.size(), 32'd0);
    finish_run();
  end
endmodule